// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block models a synchronous static RAM whose write data follows its command by the same number of clocks as read data does. The command, address and byte enables of a write are captured on the command edge, and the data itself is taken from the bus later, in the same bus slot a read issued on that edge would have used. Reads and writes can therefore alternate on every clock with no idle cycles between them. A mode strap selects a two-clock pipelined read path with an output register, or a one-clock flow-through path.

Accesses start on load cycles, where the address, three chip selects and the read/write input are sampled. Advance cycles ignore all of these. They step a 2-bit burst counter over the two low address bits, in interleaved or linear order as a second strap selects, and repeat the kind of access the burst began with. A clock-enable input freezes the whole pipeline. An asynchronous output enable gates the drivers. A read that hits a write still waiting for its data slot gets the newer bytes, so it never sees stale contents. The bidirectional bus is modelled as an input port, an output port and a drive flag.

Top module: `ztSram`

## Requirements
- R1: With flowThru=0 (pipelined), a read accepted on enabled edge k drives its word on dataOut, with dataDrive=1, from just after enabled edge k+1 until enabled edge k+2. An enabled edge is a rising clk edge with freezeIn=0.
- R2: With flowThru=1 (flow-through), a read accepted on enabled edge k drives its word from just after edge k until enabled edge k+1.
- R3: A write accepted on enabled edge k stores dataIn as sampled on enabled edge k+2 (pipelined) or k+1 (flow-through). Reads and writes may be issued on consecutive edges in any order, with no idle cycles.
- R4: On a load cycle (advance=0) the device is selected only when csLoN=0, csHi=1 and csAltN=0; readNotWrite=1 starts a read and 0 starts a write. A deselected load is a no-operation that leaves the bus undriven, while accesses already accepted still complete.
- R5: On an advance cycle (advance=1), addrIn, the chip selects and readNotWrite are ignored. The cycle repeats the kind of the last load (read, write or no-operation), so advancing after a deselect stays deselected.
- R6: A burst keeps the upper address bits of its load address. Its low two bits are start XOR n with interleave=1, or (start + n) mod 4 with interleave=0, where n counts advances modulo 4. The sequence wraps back to the start address on every fourth access.
- R7: byteWrN is active low per lane. Bit i=0 lets the write store dataIn[8i+7:8i] and leaves the other lanes unchanged. A write with all byteWrN bits at 1 stores nothing.
- R8: While freezeIn=1, no register advances and no write is stored. dataOut and dataDrive keep their values, so a read in its data slot stays driven and a write slot stays undriven.
- R9: dataDrive is 0 in any cycle whose data slot belongs to a write or a no-operation, and whenever outEnN=1. outEnN acts without waiting for a clock.
- R10: A read whose address matches a write that has not yet received its data returns that write's enabled lanes merged over the stored word.
- R11: While rst=1 at a rising edge (synchronous reset), all pending accesses are dropped, the burst kind becomes no-operation, and dataDrive and dataOut read 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freezeIn | input | 1 | 1 freezes the whole pipeline |
| csLoN | input | 1 | Chip select, active low |
| csHi | input | 1 | Chip select, active high |
| csAltN | input | 1 | Chip select, active low |
| advance | input | 1 | 1 = advance the burst, 0 = load a new access |
| readNotWrite | input | 1 | On a load: 1 = read, 0 = write |
| byteWrN | input | LANES | Per-lane write enables, active low |
| addrIn | input | ADDR_W | Word address |
| interleave | input | 1 | Burst order strap: 1 = XOR order, 0 = linear |
| flowThru | input | 1 | Mode strap: 1 = flow-through, 0 = pipelined |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataIn | input | LANES*8 | Bus value as seen by the device (write data) |
| dataOut | output | LANES*8 | Read data, 0 when not driving |
| dataDrive | output | 1 | 1 when the device drives the bus |

## Verification
The assertions check on every cycle that a freeze leaves both pipeline stages untouched and that a deselected load puts nothing in the pipeline. They also check that each advance stays inside the burst's 4-word group with an unchanged access kind, and that no cycle both stores a write and drives the bus. The data-slot timing in both modes, the byte-lane merging, the read-after-write forwarding and the burst sequences are shown only by the bench. It sweeps all four strap combinations with full write and read passes, back-to-back write/read pairs to the same address, directed lane and burst cases, and a long mixed stream with freezes, deselects and output-enable toggles, all checked against its own memory image.

// File: rtl/ztSramPkg.sv
package ztSramPkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commitWr;    // store the data-slot write on this edge
    logic captureOut;  // load the pipelined output register
    logic fwdHit;      // pending write matches the read address
    logic flowSel;     // flow-through path selected
    logic readPhase;   // current data slot belongs to a read
  } dpStrobe_t;

  function automatic logic [1:0] burstLow(input logic [1:0] startLow,
                                          input logic [1:0] stepCnt,
                                          input logic       xorOrder);
    return xorOrder ? (startLow ^ stepCnt) : (startLow + stepCnt);
  endfunction

endpackage

// File: rtl/ztSramCtrl.sv
module ztSramCtrl
  import ztSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freezeIn,
  input  logic              csLoN,
  input  logic              csHi,
  input  logic              csAltN,
  input  logic              advance,
  input  logic              readNotWrite,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              interleave,
  input  logic              flowThru,
  output dpStrobe_t         st,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrBen
);

  logic stepEn;
  assign stepEn = ~freezeIn;

  // burst state
  opKind_e           burstKind;
  logic [ADDR_W-1:0] burstBase;
  logic [1:0]        burstStart;
  logic [1:0]        burstCnt;
  logic [1:0]        cntNext;

  // pipeline stages
  opKind_e           s1Kind, s2Kind;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1Ben, s2Ben;

  opKind_e           nxtKind;
  logic [ADDR_W-1:0] nxtAddr;
  logic              selected;

  assign selected = ~csLoN & csHi & ~csAltN;
  assign cntNext  = burstCnt + 2'd1;

  always_comb begin
    if (!advance) begin
      nxtKind = selected ? (readNotWrite ? OP_READ : OP_WRITE) : OP_NONE;
      nxtAddr = addrIn;
    end else begin
      nxtKind = burstKind;
      nxtAddr = {burstBase[ADDR_W-1:2], burstLow(burstStart, cntNext, interleave)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burstKind  <= OP_NONE;
      burstBase  <= '0;
      burstStart <= '0;
      burstCnt   <= '0;
      s1Kind     <= OP_NONE;
      s2Kind     <= OP_NONE;
      s1Addr     <= '0;
      s2Addr     <= '0;
      s1Ben      <= '1;
      s2Ben      <= '1;
    end else if (stepEn) begin
      if (!advance) begin
        burstKind  <= nxtKind;
        burstBase  <= addrIn;
        burstStart <= addrIn[1:0];
        burstCnt   <= '0;
      end else begin
        burstCnt   <= cntNext;
      end
      s1Kind <= nxtKind;
      s1Addr <= nxtAddr;
      s1Ben  <= byteWrN;
      s2Kind <= s1Kind;
      s2Addr <= s1Addr;
      s2Ben  <= s1Ben;
    end
  end

  // the access whose data slot is the current bus cycle
  opKind_e dpKind;
  assign dpKind = flowThru ? s1Kind : s2Kind;
  assign wrAddr = flowThru ? s1Addr : s2Addr;
  assign wrBen  = flowThru ? s1Ben  : s2Ben;
  assign rdAddr = s1Addr;

  always_comb begin
    st.commitWr   = stepEn & (dpKind == OP_WRITE);
    st.captureOut = stepEn & ~flowThru;
    st.fwdHit     = ~flowThru & (s2Kind == OP_WRITE) & (s2Addr == s1Addr);
    st.flowSel    = flowThru;
    st.readPhase  = (dpKind == OP_READ);
  end

  // R8: a frozen edge leaves both stages untouched
  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (rst)
    freezeIn |=> ($stable(s1Kind) && $stable(s1Addr) && $stable(s2Kind) && $stable(s2Addr)));

  // R4: a deselected load puts nothing in the pipeline
  assert_desel_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!freezeIn && !advance && (csLoN || !csHi || csAltN)) |=> (s1Kind == OP_NONE));

  // R6: an advance inside an active burst stays in the same 4-word group
  assert_burst_group_R6: assert property (@(posedge clk) disable iff (rst)
    (!freezeIn && advance && burstKind != OP_NONE)
      |=> (s1Addr[ADDR_W-1:2] == $past(s1Addr[ADDR_W-1:2])) && (s1Kind == $past(s1Kind)));

  // R5: advance cycles never change the burst kind
  assert_burst_kind_R5: assert property (@(posedge clk) disable iff (rst)
    (!freezeIn && advance) |=> $stable(burstKind));

endmodule

// File: rtl/ztSramData.sv
module ztSramData
  import ztSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpStrobe_t               st,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        wrBen,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] rdData
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk) begin
    if (st.commitWr) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wrBen[l]) mem[wrAddr][l*LANE_W +: LANE_W] <= dataIn[l*LANE_W +: LANE_W];
      end
    end
  end

  // forward lanes of the write committing on this same edge
  always_comb begin
    merged = mem[rdAddr];
    if (st.fwdHit) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wrBen[l]) merged[l*LANE_W +: LANE_W] = dataIn[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 outReg <= '0;
    else if (st.captureOut)  outReg <= merged;
  end

  assign rdData = st.flowSel ? merged : outReg;

endmodule

// File: rtl/ztSram.sv
module ztSram
  import ztSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freezeIn,
  input  logic               csLoN,
  input  logic               csHi,
  input  logic               csAltN,
  input  logic               advance,
  input  logic               readNotWrite,
  input  logic [LANES-1:0]   byteWrN,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               interleave,
  input  logic               flowThru,
  input  logic               outEnN,
  input  logic [LANES*8-1:0] dataIn,
  output logic [LANES*8-1:0] dataOut,
  output logic               dataDrive
);

  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  dpStrobe_t         st;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [LANES-1:0]  wrBen;
  logic [DATA_W-1:0] rdData;

  ztSramCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rst(rst), .freezeIn(freezeIn),
    .csLoN(csLoN), .csHi(csHi), .csAltN(csAltN),
    .advance(advance), .readNotWrite(readNotWrite), .byteWrN(byteWrN),
    .addrIn(addrIn), .interleave(interleave), .flowThru(flowThru),
    .st(st), .rdAddr(rdAddr), .wrAddr(wrAddr), .wrBen(wrBen)
  );

  ztSramData #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rst(rst), .st(st),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrBen(wrBen),
    .dataIn(dataIn), .rdData(rdData)
  );

  assign dataDrive = st.readPhase & ~outEnN;
  assign dataOut   = dataDrive ? rdData : '0;

  // R9: a cycle that stores write data never drives the bus
  assert_no_drive_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    st.commitWr |-> !dataDrive);

endmodule

// File: tb/sim_ztSram.sv
module sim_ztSram;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        freezeIn = 1'b0, csLoN = 1'b1, csHi = 1'b0, csAltN = 1'b0;
  logic        advance = 1'b0, readNotWrite = 1'b1;
  logic [3:0]  byteWrN = 4'hF;
  logic [7:0]  addrIn = '0;
  logic        interleave = 1'b0, flowThru = 1'b0, outEnN = 1'b0;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        dataDrive;

  always #(CLK_PERIOD/2) clk = ~clk;

  ztSram u0 (
    .clk(clk), .rst(rst), .freezeIn(freezeIn), .csLoN(csLoN), .csHi(csHi), .csAltN(csAltN),
    .advance(advance), .readNotWrite(readNotWrite), .byteWrN(byteWrN), .addrIn(addrIn),
    .interleave(interleave), .flowThru(flowThru), .outEnN(outEnN), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  int checks = 0, fails = 0;
  int nEdge = 0, lastCommit = 0;
  int opKindQ [16];   // 0 none, 1 read, 2 write
  int opBurstQ [16];
  logic [7:0]  opAddrQ [16];
  logic [3:0]  opBenQ  [16];
  logic [31:0] opDataQ [16];
  logic [31:0] refMem [256];
  int bKind = 0;
  logic [7:0] bBase = '0;
  logic [1:0] bStart = '0, bCnt = '0;
  bit prevFrozen = 0;
  string tagOverride = "";
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[30:16], seed[14:0], seed[31], seed[15]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at edge %0d", tag, act, exp, nEdge);
    end
  endtask

  function automatic int lat();
    return flowThru ? 1 : 2;
  endfunction

  task automatic commitUpTo(input int limit);
    for (int j = lastCommit + 1; j <= limit; j++) begin
      if (opKindQ[j & 15] == 2) begin
        for (int l = 0; l < 4; l++)
          if (!opBenQ[j & 15][l]) refMem[opAddrQ[j & 15]][l*8 +: 8] = opDataQ[j & 15][l*8 +: 8];
      end
    end
    if (limit > lastCommit) lastCommit = limit;
  endtask

  // one bus cycle; called just after a falling edge
  task automatic doCycle(input bit frz, input bit adv, input bit rw, input bit [2:0] cs,
                         input logic [7:0] a, input logic [3:0] ben, input bit oen);
    int w, wq, nx, nq, kind;
    bit expDrive, fwd;
    string tag;
    logic [31:0] expData;
    commitUpTo(nEdge - lat());
    w  = nEdge - lat() + 1;
    wq = w & 15;
    outEnN = oen;
    if (w >= 1 && opKindQ[wq] == 2) dataIn = opDataQ[wq];
    else dataIn = rnd();
    freezeIn = frz; advance = adv; readNotWrite = rw;
    {csLoN, csHi, csAltN} = cs;
    addrIn = a; byteWrN = ben;
    #1;
    kind = (w >= 1) ? opKindQ[wq] : 0;
    fwd = 0;
    for (int d = 1; d <= 2; d++)
      if (w - d >= 1 && opKindQ[(w-d) & 15] == 2 && opAddrQ[(w-d) & 15] == opAddrQ[wq]) fwd = 1;
    if (tagOverride != "") tag = tagOverride;
    else if (prevFrozen) tag = "R8";
    else if (oen) tag = "R9";
    else if (kind == 2) tag = "R3";
    else if (kind == 0) tag = "R4";
    else if (opBurstQ[wq] != 0) tag = "R6";
    else if (fwd) tag = "R10";
    else if (flowThru) tag = "R2";
    else tag = "R1";
    expDrive = (kind == 1) && !oen;
    chk(dataDrive == expDrive, tag, {31'd0, dataDrive}, {31'd0, expDrive});
    if (expDrive) begin
      expData = refMem[opAddrQ[wq]];
      chk(dataOut === expData, tag, dataOut, expData);
    end
    if (!frz) begin
      nx = nEdge + 1; nq = nx & 15;
      if (!adv) begin
        bKind = (cs[2] || !cs[1] || cs[0]) ? 0 : (rw ? 1 : 2);
        bBase = a; bStart = a[1:0]; bCnt = 2'd0;
        opAddrQ[nq] = a; opBurstQ[nq] = 0;
      end else begin
        bCnt = bCnt + 2'd1;
        opAddrQ[nq] = {bBase[7:2], interleave ? (bStart ^ bCnt) : (bStart + bCnt)};
        opBurstQ[nq] = 1;
      end
      opKindQ[nq] = bKind;
      opBenQ[nq]  = ben;
      opDataQ[nq] = rnd();
    end
    @(posedge clk);
    if (!frz) nEdge++;
    prevFrozen = frz;
    @(negedge clk);
  endtask

  task automatic ld(input bit rw, input logic [7:0] a, input logic [3:0] ben);
    doCycle(1'b0, 1'b0, rw, 3'b010, a, ben, 1'b0);
  endtask

  task automatic nop();
    doCycle(1'b0, 1'b0, 1'b1, 3'b110, 8'h00, 4'hF, 1'b0);
  endtask

  task automatic resetWith(input bit ft, input bit il);
    nop(); nop(); nop();
    commitUpTo(nEdge);
    rst = 1'b1;
    flowThru = ft; interleave = il;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dataDrive == 1'b0 && dataOut == 32'd0, "R11", {31'd0, dataDrive}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) opKindQ[i] = 0;
    lastCommit = nEdge;
    bKind = 0;
    prevFrozen = 0;
    // advance right after reset stays idle
    doCycle(1'b0, 1'b1, 1'b1, 3'b010, 8'h10, 4'h0, 1'b0);
  endtask

  task automatic randomCycle();
    logic [31:0] r;
    bit [2:0] cs;
    logic [3:0] ben;
    int sel, bsel;
    r = rnd();
    sel = int'(r[8:6]);
    cs = (sel == 0) ? 3'b110 : (sel == 1) ? 3'b000 : (sel == 2) ? 3'b011 : 3'b010;
    bsel = int'(r[12:9]) % 6;
    ben = (bsel == 0) ? 4'hF : (bsel < 3) ? r[19:16] : 4'h0;
    doCycle(r[2:0] == 3'd0, (r[5:3] < 3'd3), r[13], cs, {3'b000, r[24:20]}, ben,
            (r[28:25] == 4'd0));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      opKindQ[i] = 0; opBurstQ[i] = 0; opAddrQ[i] = '0; opBenQ[i] = '1; opDataQ[i] = '0;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dataDrive == 1'b0 && dataOut == 32'd0, "R11", {31'd0, dataDrive}, 32'd0);
    rst = 1'b0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      resetWith(cfg[1], cfg[0]);
      for (int a = 0; a < 256; a++) ld(1'b0, 8'(a), 4'h0);
      for (int a = 0; a < 256; a++) ld(1'b1, 8'(a), 4'h0);
      // write then read of the same word on consecutive edges
      for (int a = 0; a < 64; a++) begin
        ld(1'b0, 8'(a * 3), 4'h0);
        ld(1'b1, 8'(a * 3), 4'h0);
      end
      // R7: lane gating and abort
      tagOverride = "R7";
      ld(1'b0, 8'd200, 4'h0);
      ld(1'b0, 8'd200, 4'b1010);
      ld(1'b0, 8'd200, 4'b1111);
      ld(1'b1, 8'd200, 4'h0);
      nop(); nop(); nop();
      ld(1'b1, 8'd200, 4'h0);
      nop(); nop();
      // R5: advances with garbage on the ignored inputs
      tagOverride = "R5";
      ld(1'b1, 8'd66, 4'h0);
      for (int k = 0; k < 5; k++) doCycle(1'b0, 1'b1, 1'b0, 3'b110, 8'hFF, 4'h0, 1'b0);
      ld(1'b0, 8'd129, 4'hC);
      for (int k = 0; k < 3; k++) doCycle(1'b0, 1'b1, 1'b1, 3'b101, 8'h3C, 4'h3, 1'b0);
      ld(1'b1, 8'd128, 4'h0);
      for (int k = 0; k < 3; k++) doCycle(1'b0, 1'b1, 1'b0, 3'b000, 8'hA5, 4'h0, 1'b0);
      nop(); nop();
      tagOverride = "";
      for (int k = 0; k < 700; k++) randomCycle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule